// File: doc/BRIEF.md
# Microprogrammed Multicycle Control Sequencer

This block steers the datapath of a multicycle 32-bit load/store processor. Every control state is one microword in a small on-chip control store. A microprogram counter selects the current word, and the word's fields drive the datapath control lines for that cycle. The word also carries a 2-bit sequencing code, which picks where the counter goes next.

There are four choices for the next address:
- back to the fetch word;
- the first opcode dispatch table;
- the second opcode dispatch table;
- the current address plus one.

The first table splits decoded instructions into the memory-access, register-register, branch-on-equal and jump microroutines. The second table separates a load from a store once the effective address has been formed. Five instruction kinds are supported: lw (100011), sw (101011), R-type (000000), beq (000100) and j (000010). Any other opcode falls back to fetch.

The control store is read synchronously on the same edge that updates the counter, so every control output is a register.

Top module: `mpc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer enters address 0. In the following cycle it shows the fetch controls of R2, whatever the previous state was.
- R2: Address 0 (fetch) asserts `mem_read`, `ir_write` and `pc_write`, with `iord`=0, `alu_src_a`=0 (PC), `alu_src_b`=01 (constant 4), `alu_op`=00 (add) and `pc_source`=00 (ALU result). It always moves to address 1 next.
- R3: Address 1 (decode) drives `alu_src_a`=0, `alu_src_b`=11 (immediate sign-extended and shifted left by two) and `alu_op`=00, with every write and memory strobe low. It then dispatches through table 1.
- R4: Table 1 maps the opcode present in address 1 to a target: 100011 and 101011 go to 2, 000000 goes to 6, 000100 goes to 8, and 000010 goes to 9.
- R5: Table 2 maps the opcode present in address 2 to a target: 100011 goes to 3 and 101011 goes to 5.
- R6: The memory states drive these controls:
  - address 2 drives `alu_src_a`=1, `alu_src_b`=10 and `alu_op`=00;
  - address 3 drives `mem_read` with `iord`=1, then goes on to 4;
  - address 4 drives `reg_write` with `reg_dst`=0 and `mem_to_reg`=1;
  - address 5 drives `mem_write` with `iord`=1.

  Addresses 4 and 5 return to 0.
- R7: Address 6 drives `alu_src_a`=1, `alu_src_b`=00 and `alu_op`=10 (function field), then goes on to 7. Address 7 drives `reg_write` with `reg_dst`=1 and `mem_to_reg`=0, then returns to 0.
- R8: Address 8 drives `alu_src_a`=1, `alu_src_b`=00, `alu_op`=01 (subtract), `pc_write_cond` and `pc_source`=01. Address 9 drives `pc_write` with `pc_source`=10. Both return to 0.
- R9: An opcode outside the five listed, if present at a dispatch, sends the sequencer to address 0.
- R10: `mem_read` and `mem_write` are never high together, and neither are `pc_write` and `pc_write_cond`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction opcode field |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write qualified by ALU zero |
| iord | output | 1 | Memory address source: 0 PC, 1 ALUOut |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_write | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data: 0 ALUOut, 1 MDR |
| pc_source | output | 2 | PC source: 00 ALU, 01 ALUOut, 10 jump target |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field |
| alu_src_a | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B input: 00 B, 01 four, 10 imm, 11 imm shifted |
| reg_write | output | 1 | Register file write |
| reg_dst | output | 1 | Destination: 0 rt, 1 rd |

## Verification
The bench builds the block with its default sizes: a 6-bit opcode and a 4-bit microaddress. With these sizes it can present all 64 opcodes, one instruction after another, with no reset between them. This covers every entry of both dispatch tables, every unsupported code and every microword in sequence. A reset forced midway through a load exercises the return to fetch from a state that is not terminal.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'b00,
    SEQ_DISP1 = 2'b01,
    SEQ_DISP2 = 2'b10,
    SEQ_NEXT  = 2'b11
  } seq_e;

  // Seven non-overlapping fields; each control line belongs to one field.
  typedef struct packed {
    logic [1:0] alu_op;       // ALU control field
    logic       src_a;        // first operand field
    logic [1:0] src_b;        // second operand field
    logic       reg_wr;       // register control field
    logic       reg_dst;
    logic       mem_to_reg;
    logic       mem_rd;       // memory field
    logic       mem_wr;
    logic       i_or_d;
    logic       ir_wr;
    logic       pc_wr;        // PC write field
    logic       pc_wr_cond;
    logic [1:0] pc_src;
    seq_e       seq;          // sequencing field
  } uword_t;

  localparam int UWORD_W = $bits(uword_t);

  function automatic uword_t ucode_word(input int unsigned addr);
    uword_t w;
    w = '0;
    w.seq = SEQ_FETCH;
    case (addr)
      0: begin
        w.mem_rd = 1'b1; w.ir_wr = 1'b1; w.pc_wr = 1'b1;
        w.src_b = 2'b01; w.seq = SEQ_NEXT;
      end
      1: begin w.src_b = 2'b11; w.seq = SEQ_DISP1; end
      2: begin w.src_a = 1'b1; w.src_b = 2'b10; w.seq = SEQ_DISP2; end
      3: begin w.mem_rd = 1'b1; w.i_or_d = 1'b1; w.seq = SEQ_NEXT; end
      4: begin w.reg_wr = 1'b1; w.mem_to_reg = 1'b1; end
      5: begin w.mem_wr = 1'b1; w.i_or_d = 1'b1; end
      6: begin w.src_a = 1'b1; w.alu_op = 2'b10; w.seq = SEQ_NEXT; end
      7: begin w.reg_wr = 1'b1; w.reg_dst = 1'b1; end
      8: begin
        w.src_a = 1'b1; w.alu_op = 2'b01; w.pc_wr_cond = 1'b1; w.pc_src = 2'b01;
      end
      9: begin w.pc_wr = 1'b1; w.pc_src = 2'b10; end
      default: ;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mpc_ucode_rom.sv
module mpc_ucode_rom
  import mpc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] raddr,
  output uword_t            rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  uword_t store [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign store[g] = ucode_word(g);
  end

  // Synchronous read so the store maps onto a block RAM read port.
  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end

endmodule

// File: rtl/mpc_dispatch.sv
module mpc_dispatch
  import mpc_pkg::*;
#(
  parameter int OP_W     = 6,
  parameter int ADDR_W   = 4,
  parameter int TABLE_ID = 1
) (
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] target
);

  if (TABLE_ID == 1) begin : g_tab1
    always_comb begin
      case (opcode)
        OP_W'(OPC_LOAD), OP_W'(OPC_STORE): target = ADDR_W'(2);
        OP_W'(OPC_RTYPE):                  target = ADDR_W'(6);
        OP_W'(OPC_BEQ):                    target = ADDR_W'(8);
        OP_W'(OPC_JUMP):                   target = ADDR_W'(9);
        default:                           target = '0;
      endcase
    end
  end else begin : g_tab2
    always_comb begin
      case (opcode)
        OP_W'(OPC_LOAD):  target = ADDR_W'(3);
        OP_W'(OPC_STORE): target = ADDR_W'(5);
        default:          target = '0;
      endcase
    end
  end

endmodule

// File: rtl/mpc_addr_sel.sv
module mpc_addr_sel
  import mpc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  seq_e              seq,
  input  logic [ADDR_W-1:0] disp1,
  input  logic [ADDR_W-1:0] disp2,
  output logic [ADDR_W-1:0] next_addr
);

  logic [ADDR_W-1:0] incr;

  assign incr = cur_addr + ADDR_W'(1);

  always_comb begin
    case (seq)
      SEQ_DISP1: next_addr = disp1;
      SEQ_DISP2: next_addr = disp2;
      SEQ_NEXT:  next_addr = incr;
      default:   next_addr = '0;
    endcase
  end

endmodule

// File: rtl/mpc_sequencer.sv
module mpc_sequencer
  import mpc_pkg::*;
#(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic       pc_write,
  output logic       pc_write_cond,
  output logic       iord,
  output logic       mem_read,
  output logic       mem_write,
  output logic       ir_write,
  output logic       mem_to_reg,
  output logic [1:0] pc_source,
  output logic [1:0] alu_op,
  output logic       alu_src_a,
  output logic [1:0] alu_src_b,
  output logic       reg_write,
  output logic       reg_dst
);

  logic [ADDR_W-1:0] upc;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] d1_tgt;
  logic [ADDR_W-1:0] d2_tgt;
  logic [OP_W-1:0]   op_i;
  uword_t            word;

  assign op_i = OP_W'(opcode);

  mpc_dispatch #(.OP_W(OP_W), .ADDR_W(ADDR_W), .TABLE_ID(1)) u_disp1 (
    .opcode(op_i), .target(d1_tgt)
  );

  mpc_dispatch #(.OP_W(OP_W), .ADDR_W(ADDR_W), .TABLE_ID(2)) u_disp2 (
    .opcode(op_i), .target(d2_tgt)
  );

  mpc_addr_sel #(.ADDR_W(ADDR_W)) u_asel (
    .cur_addr(upc), .seq(word.seq), .disp1(d1_tgt), .disp2(d2_tgt),
    .next_addr(nxt)
  );

  assign rd_addr = rst ? '0 : nxt;

  // Counter and control-store read advance on the same edge, keeping them aligned.
  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= nxt;
  end

  mpc_ucode_rom #(.ADDR_W(ADDR_W)) u_rom (
    .clk(clk), .raddr(rd_addr), .rdata(word)
  );

  assign pc_write      = word.pc_wr;
  assign pc_write_cond = word.pc_wr_cond;
  assign iord          = word.i_or_d;
  assign mem_read      = word.mem_rd;
  assign mem_write     = word.mem_wr;
  assign ir_write      = word.ir_wr;
  assign mem_to_reg    = word.mem_to_reg;
  assign pc_source     = word.pc_src;
  assign alu_op        = word.alu_op;
  assign alu_src_a     = word.src_a;
  assign alu_src_b     = word.src_b;
  assign reg_write     = word.reg_wr;
  assign reg_dst       = word.reg_dst;

  logic op_known;
  assign op_known = (opcode == OPC_RTYPE) || (opcode == OPC_LOAD) ||
                    (opcode == OPC_STORE) || (opcode == OPC_BEQ) ||
                    (opcode == OPC_JUMP);

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_read && mem_write)); // R10
  AST_PC_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pc_write && pc_write_cond)); // R10
  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    (upc == '0) |=> (upc == ADDR_W'(1) && alu_src_b == 2'b11)); // R3
  AST_BEQ_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    (upc == ADDR_W'(1) && opcode == OPC_BEQ) |=> (pc_write_cond && pc_source == 2'b01)); // R4
  AST_LOAD_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    (upc == ADDR_W'(2) && opcode == OPC_LOAD) |=> (mem_read && iord)); // R5
  AST_BAD_OP_FETCH: assert property (@(posedge clk) disable iff (rst)
    (upc == ADDR_W'(1) && !op_known) |=> (ir_write && upc == '0)); // R9

endmodule

// File: tb/mpc_sequencer_bench.sv
module mpc_sequencer_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       pc_write, pc_write_cond, iord, mem_read, mem_write, ir_write;
  logic       mem_to_reg, alu_src_a, reg_write, reg_dst;
  logic [1:0] pc_source, alu_op, alu_src_b;

  int n_checks = 0;
  int n_fail   = 0;
  int model    = 0;
  int prev     = 0;
  logic prev_rst = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpc_sequencer u_mpc_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_write(pc_write), .pc_write_cond(pc_write_cond), .iord(iord),
    .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write),
    .mem_to_reg(mem_to_reg), .pc_source(pc_source), .alu_op(alu_op),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .reg_write(reg_write),
    .reg_dst(reg_dst)
  );

  function automatic bit known(input logic [5:0] op);
    return op == 6'b000000 || op == 6'b100011 || op == 6'b101011 ||
           op == 6'b000100 || op == 6'b000010;
  endfunction

  function automatic int next_of(input int s, input logic [5:0] op);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'b100011 || op == 6'b101011) return 2;
        if (op == 6'b000000) return 6;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        return 0;
      end
      2: return (op == 6'b100011) ? 3 : (op == 6'b101011) ? 5 : 0;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  // {pcw, pcwc, iord, mrd, mwr, irw, m2r, pcsrc[2], aluop[2], srca, srcb[2], rw, rdst}
  function automatic logic [15:0] ctrl_of(input int s);
    logic pw, pc, io, mr, mw, iw, mg, sa, rw, rd;
    logic [1:0] ps, ao, sb;
    {pw, pc, io, mr, mw, iw, mg, sa, rw, rd} = '0;
    ps = 2'b00; ao = 2'b00; sb = 2'b00;
    case (s)
      0: begin mr = 1; iw = 1; pw = 1; sb = 2'b01; end
      1: sb = 2'b11;
      2: begin sa = 1; sb = 2'b10; end
      3: begin mr = 1; io = 1; end
      4: begin rw = 1; mg = 1; end
      5: begin mw = 1; io = 1; end
      6: begin sa = 1; ao = 2'b10; end
      7: begin rw = 1; rd = 1; end
      8: begin sa = 1; ao = 2'b01; pc = 1; ps = 2'b01; end
      9: begin pw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {pw, pc, io, mr, mw, iw, mg, ps, ao, sa, sb, rw, rd};
  endfunction

  function automatic string tag_of(input int s, input int p, input logic pr,
                                   input logic [5:0] op);
    if (pr) return "R1";
    if (p == 1) return known(op) ? "R4" : "R9";
    if (p == 2) return "R5";
    case (s)
      0: return "R2";
      1: return "R3";
      2, 3, 4, 5: return "R6";
      6, 7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_now();
    logic [15:0] got, exp;
    string tg;
    got = {pc_write, pc_write_cond, iord, mem_read, mem_write, ir_write,
           mem_to_reg, pc_source, alu_op, alu_src_a, alu_src_b, reg_write, reg_dst};
    exp = ctrl_of(model);
    tg  = tag_of(model, prev, prev_rst, opcode);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s state %0d op %b: got %h expected %h", tg, model, opcode, got, exp);
    end
    n_checks++;
    if ((mem_read && mem_write) || (pc_write && pc_write_cond)) begin
      n_fail++;
      $display("FAIL R10 exclusive strobes: got %h expected no conflict", got);
    end
  endtask

  task automatic step();
    @(posedge clk);
    prev     = model;
    prev_rst = rst;
    model    = rst ? 0 : next_of(model, opcode);
    @(negedge clk);
    check_now();
  endtask

  initial begin
    rst = 1'b1;
    @(negedge clk);
    step();
    step();
    rst = 1'b0;
    // Sweep every opcode, one instruction each, no reset between.
    for (int op = 0; op < 64; op++) begin
      while (model != 0) step();
      opcode = op[5:0];
      for (int k = 0; k < 6; k++) step();
    end
    // Reset during the load's memory read state.
    while (model != 0) step();
    opcode = 6'b100011;
    while (model != 3) step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    for (int k = 0; k < 6; k++) step();
    // Back-to-back jumps and branches.
    for (int r = 0; r < 4; r++) begin
      while (model != 0) step();
      opcode = r[0] ? 6'b000010 : 6'b000100;
      for (int k = 0; k < 3; k++) step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule